// File: doc/BRIEF.md
# Flow-Controlled Serial Character Transmitter

This block turns bytes written by a host into asynchronous serial frames on a single output line. A write places a byte in a one-entry holding buffer. As soon as the frame shifter is idle, and the modem's clear-to-send line reports ready, the buffered byte moves into the shifter. The shifter then sends a low start bit, the selected number of data bits with the least significant bit first, and a high stop bit. Each bit lasts sixteen baud ticks. The holding buffer frees up the moment its byte moves into the shifter, so the host can queue the next character while the current one is still going out.

Flow control acts only between characters. The active-low clear-to-send pin passes through a two-flop synchronizer. Its synchronized value is looked at only when a new start bit is about to be issued. A character that is already on the line always finishes, even if clear-to-send is withdrawn part way through. Any character left in the buffer then waits until clear-to-send returns. Two status outputs tell the host whether the buffer can take a byte and whether the whole transmitter has gone quiet.

Top module: `uart_cts_tx`

## Requirements
- R1: After reset, `txd` is 1, `tx_buf_empty` is 1 and `tx_done` is 1.
- R2: A frame is a start bit of 0, then N data bits least significant bit first, then a stop bit of 1. N = 5 + `word_len` (`word_len` 0→5, 1→6, 2→7, 3→8). Each bit lasts 16 `baud_tick` pulses. The line is 1 whenever the shifter is idle.
- R3: Bits of `wr_data` at positions N and above never appear on the line.
- R4: A cycle with `wr_en` high makes both `tx_buf_empty` and `tx_done` read 0 in the following cycle.
- R5: `tx_buf_empty` returns to 1 once the byte moves into the shifter, which is while its frame is still being sent. `tx_done` stays 0 at that point.
- R6: While `cts_n` is 1 (synchronized), no start bit is issued. A written byte stays buffered, with `tx_buf_empty` at 0, and is sent after `cts_n` returns to 0.
- R7: If `cts_n` rises during a frame, that frame completes intact. A byte already waiting in the buffer does not start until `cts_n` is 0 again.
- R8: `tx_done` becomes 1 after the stop bit finishes, provided the buffer is empty. `tx_done` at 1 implies `tx_buf_empty` at 1 and `txd` at 1.
- R9: A byte queued during a frame starts its own start bit within a few clock cycles after the previous stop bit ends, with no idle bit time in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one cycle per byte |
| wr_data | input | 8 | Byte to transmit |
| word_len | input | 2 | Data bits per character minus five |
| baud_tick | input | 1 | One-cycle pulse at sixteen times the bit rate |
| cts_n | input | 1 | Clear-to-send from the modem, active low, asynchronous |
| txd | output | 1 | Serial data out, idles high |
| tx_buf_empty | output | 1 | Holding buffer can accept a byte |
| tx_done | output | 1 | Buffer and shifter both empty, last stop bit finished |

## Verification
The hardest situation to reach is a byte that is already waiting in the buffer at the moment clear-to-send is withdrawn in the middle of a frame. In that state the current frame must still complete, and the waiting byte must stay put. To get there, the bench writes a first byte and waits for the buffer to free up. It then writes a second byte, and it raises `cts_n` about three bit times into the first frame while a receiver model decodes the line in parallel. The bench then holds `cts_n` high across several idle bit times and watches that the line stays high, before releasing it and decoding the second frame. Frame contents are swept over every word length with several data patterns, and the expected value is the written byte masked to N bits.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    localparam int DATA_W     = 8;
    localparam int MIN_BITS   = 5;
    localparam int OVERSAMPLE = 16;
    localparam int CNT_W      = $clog2(DATA_W + 1);

    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_START = 2'd1,
        SH_DATA  = 2'd2,
        SH_STOP  = 2'd3
    } sh_state_e;
endpackage

// File: rtl/cts_sync.sv
module cts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_n,
    output logic cts_ok
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], cts_n};
    end

    // Reset to the negated level so no start bit can issue before the pin is seen.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign cts_ok = ~sync_q[STAGES-1];
endmodule

// File: rtl/tx_holding.sv
module tx_holding #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) st_d.full = 1'b0;
        // A write in the same cycle as a take refills the slot with the new byte.
        if (wr_en) begin
            st_d.full = 1'b1;
            st_d.data = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full = st_q.full;
    assign data = st_q.data;
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int OS  = OVERSAMPLE,
    parameter int CW  = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic [CW-1:0] load_bits,
    output logic          txd,
    output logic          idle
);
    localparam int TW = $clog2(OS);

    typedef struct packed {
        sh_state_e     state;
        logic [TW-1:0] tick;
        logic [CW-1:0] bit_idx;
        logic [CW-1:0] nbits;
        logic [DW-1:0] shreg;
        logic          txd;
    } sh_t;

    sh_t st_d, st_q;
    logic bit_end;

    always_comb begin
        st_d    = st_q;
        bit_end = baud_tick && (st_q.tick == TW'(OS - 1));
        if (st_q.state == SH_IDLE) begin
            st_d.txd = 1'b1;
            if (load) begin
                st_d.state   = SH_START;
                st_d.txd     = 1'b0;
                st_d.shreg   = load_data;
                st_d.nbits   = load_bits;
                st_d.tick    = '0;
                st_d.bit_idx = '0;
            end
        end else if (baud_tick) begin
            st_d.tick = bit_end ? '0 : st_q.tick + TW'(1);
            if (bit_end) begin
                unique case (st_q.state)
                    SH_START: begin
                        st_d.state   = SH_DATA;
                        st_d.txd     = st_q.shreg[0];
                        st_d.shreg   = st_q.shreg >> 1;
                        st_d.bit_idx = '0;
                    end
                    SH_DATA: begin
                        if (st_q.bit_idx == st_q.nbits - CW'(1)) begin
                            st_d.state = SH_STOP;
                            st_d.txd   = 1'b1;
                        end else begin
                            st_d.bit_idx = st_q.bit_idx + CW'(1);
                            st_d.txd     = st_q.shreg[0];
                            st_d.shreg   = st_q.shreg >> 1;
                        end
                    end
                    SH_STOP: begin
                        st_d.state = SH_IDLE;
                        st_d.txd   = 1'b1;
                    end
                    default: st_d.state = SH_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= SH_IDLE;
            st_q.txd   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign txd  = st_q.txd;
    assign idle = (st_q.state == SH_IDLE);
endmodule

// File: rtl/uart_cts_tx.sv
module uart_cts_tx
    import uart_tx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        word_len,
    input  logic              baud_tick,
    input  logic              cts_n,
    output logic              txd,
    output logic              tx_buf_empty,
    output logic              tx_done
);
    logic              cts_ok;
    logic              buf_full;
    logic [DATA_W-1:0] buf_data;
    logic              shift_idle;
    logic              load;
    logic [CNT_W-1:0]  nbits;

    assign nbits = CNT_W'(MIN_BITS) + CNT_W'(word_len);
    assign load  = shift_idle && buf_full && cts_ok;

    cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .cts_n  (cts_n),
        .cts_ok (cts_ok)
    );

    tx_holding #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (load),
        .full    (buf_full),
        .data    (buf_data)
    );

    tx_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .load      (load),
        .load_data (buf_data),
        .load_bits (nbits),
        .txd       (txd),
        .idle      (shift_idle)
    );

    assign tx_buf_empty = ~buf_full;
    assign tx_done      = ~buf_full & shift_idle;
endmodule

// File: rtl/uart_cts_tx_chk.sv
module uart_cts_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic txd,
    input logic tx_buf_empty,
    input logic tx_done,
    input logic cts_ok,
    input logic shift_idle
);
    p_wr_clears_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !tx_buf_empty);

    p_wr_clears_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !tx_done);

    p_start_needs_cts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift_idle) |-> $past(cts_ok));

    p_idle_line_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_idle |-> txd);

    p_done_implies_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (tx_buf_empty && txd));
endmodule

bind uart_cts_tx uart_cts_tx_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .txd          (txd),
    .tx_buf_empty (tx_buf_empty),
    .tx_done      (tx_done),
    .cts_ok       (cts_ok),
    .shift_idle   (shift_idle)
);

// File: tb/tb_uart_cts_tx.sv
module tb_uart_cts_tx;
    localparam int TICK_DIV = 4;
    localparam int BIT_CLK  = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] word_len = '0;
    logic       baud_tick = 1'b0;
    logic       cts_n = 1'b1;
    logic       txd, tx_buf_empty, tx_done;

    int n_tests = 0;
    int n_fail  = 0;
    int tick_cnt = 0;
    int cycles = 0;

    uart_cts_tx dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .word_len(word_len), .baud_tick(baud_tick), .cts_n(cts_n),
        .txd(txd), .tx_buf_empty(tx_buf_empty), .tx_done(tx_done)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        tick_cnt  = (tick_cnt + 1) % TICK_DIV;
        baud_tick = (tick_cnt == 0);
        cycles    = cycles + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
        chk(!tx_buf_empty, "R4 empty cleared", int'(tx_buf_empty), 0);
        chk(!tx_done, "R4 done cleared", int'(tx_done), 0);
    endtask

    // Decode one frame; gap = clocks waited for the start edge.
    task automatic rx_frame(input int nb, output logic [7:0] data, output logic stop, output int gap);
        gap = 0; data = '0; stop = 1'b0;
        while (txd !== 1'b0 && gap < 4000) begin
            @(negedge clk); gap++;
        end
        if (gap >= 4000) begin
            chk(0, "R2 start timeout", gap, 0);
            return;
        end
        repeat (BIT_CLK / 2) @(negedge clk);
        chk(txd == 1'b0, "R2 start bit", int'(txd), 0);
        for (int i = 0; i < nb; i++) begin
            repeat (BIT_CLK) @(negedge clk);
            data[i] = txd;
        end
        repeat (BIT_CLK) @(negedge clk);
        stop = txd;
    endtask

    task automatic wait_empty();
        for (int i = 0; i < 20 && !tx_buf_empty; i++) @(negedge clk);
    endtask

    initial begin
        logic [7:0] got;
        logic       stp;
        int         gap;
        logic [7:0] pats [8] = '{8'h00, 8'hA5, 8'h5A, 8'h3C, 8'hFF, 8'h01, 8'h80, 8'hE0};

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(txd == 1'b1, "R1 txd", int'(txd), 1);
        chk(tx_buf_empty == 1'b1, "R1 empty", int'(tx_buf_empty), 1);
        chk(tx_done == 1'b1, "R1 done", int'(tx_done), 1);

        cts_n = 1'b0;
        repeat (4) @(negedge clk);

        // R2 / R3 sweep over every word length and pattern
        for (int wl = 0; wl < 4; wl++) begin
            for (int p = 0; p < 8; p++) begin
                logic [7:0] exp;
                int nb;
                nb  = 5 + wl;
                exp = pats[p] & 8'((1 << nb) - 1);
                word_len = 2'(wl);
                write_byte(pats[p]);
                repeat (3) @(negedge clk);
                chk(tx_buf_empty == 1'b1, "R5 empty after load", int'(tx_buf_empty), 1);
                chk(tx_done == 1'b0, "R5 done low in frame", int'(tx_done), 0);
                rx_frame(nb, got, stp, gap);
                chk(got == exp, "R2 R3 data", int'(got), int'(exp));
                chk(stp == 1'b1, "R2 stop bit", int'(stp), 1);
                repeat (BIT_CLK / 2 + 8) @(negedge clk);
                chk(tx_done == 1'b1, "R8 done after stop", int'(tx_done), 1);
            end
        end

        // R6: blocked while cts_n high
        word_len = 2'd3;
        cts_n = 1'b1;
        repeat (5) @(negedge clk);
        write_byte(8'h96);
        begin
            int lows = 0;
            for (int i = 0; i < 6 * BIT_CLK; i++) begin
                @(negedge clk);
                if (txd !== 1'b1) lows++;
            end
            chk(lows == 0, "R6 no start while cts high", lows, 0);
        end
        chk(tx_buf_empty == 1'b0, "R6 byte held", int'(tx_buf_empty), 0);
        chk(tx_done == 1'b0, "R6 done low while held", int'(tx_done), 0);
        cts_n = 1'b0;
        rx_frame(8, got, stp, gap);
        chk(got == 8'h96, "R6 sent after release", int'(got), 8'h96);
        repeat (BIT_CLK) @(negedge clk);

        // R7: cts withdrawn mid-frame with a byte queued
        write_byte(8'hC3);
        wait_empty();
        write_byte(8'h2D);
        fork
            rx_frame(8, got, stp, gap);
            begin
                repeat (3 * BIT_CLK) @(negedge clk);
                cts_n = 1'b1;
            end
        join
        chk(got == 8'hC3, "R7 frame completes", int'(got), 8'hC3);
        chk(stp == 1'b1, "R7 stop bit", int'(stp), 1);
        begin
            int lows = 0;
            for (int i = 0; i < 5 * BIT_CLK; i++) begin
                @(negedge clk);
                if (txd !== 1'b1) lows++;
            end
            chk(lows == 0, "R7 next not started", lows, 0);
        end
        chk(tx_buf_empty == 1'b0, "R7 byte still held", int'(tx_buf_empty), 0);
        cts_n = 1'b0;
        rx_frame(8, got, stp, gap);
        chk(got == 8'h2D, "R7 held byte sent", int'(got), 8'h2D);
        repeat (BIT_CLK) @(negedge clk);

        // R9: back-to-back frames
        word_len = 2'd1;
        write_byte(8'h15);
        wait_empty();
        write_byte(8'h2A);
        rx_frame(6, got, stp, gap);
        chk(got == 8'h15, "R9 first data", int'(got), 8'h15);
        rx_frame(6, got, stp, gap);
        chk(gap <= BIT_CLK / 2 + 8, "R9 no idle gap", gap, BIT_CLK / 2);
        chk(got == 8'h2A, "R9 second data", int'(got), 8'h2A);
        repeat (BIT_CLK) @(negedge clk);
        chk(tx_done == 1'b1, "R8 done at end", int'(tx_done), 1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        wait (cycles >= 190000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", cycles);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule